// File: doc/BRIEF.md
# Interrupt Acknowledge and Vectoring Unit

This block sits beside the fetch logic of a small 8-bit microcontroller core and turns interrupt requests into an acknowledge sequence. Each request input sets a sticky pending flag. When the global enable is set, the core signals an instruction boundary and at least one flag is pending, the unit takes the interrupt. It picks the source with the lowest vector, clears that source's flag and the global enable, and captures the current program counter and the carry and zero flags.

Over the next two cycles the unit writes the captured context into data memory as two bytes through the stack pointer, advancing the pointer after each byte. In the third cycle it loads the program counter with the fixed vector of the winning source. Vectors start at word 2 and are spaced two words apart: source 0 (bus reset) is at 0x0002, source 1 (short timer) at 0x0004 and source 2 (long timer) at 0x0006. The cycle right after reset loads the program counter with 0x0000.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset `ie_o` is 0, `pend_o` is 0 and `busy_o` is 0. In the first cycle after reset, `pc_load_o` is 1 with `pc_next_o` = 0x0000. In every later idle cycle, `pc_load_o` is 0.
- R2: A high `irq_req_i[i]` at a clock edge sets `pend_o[i]`. The flag stays set, whether or not interrupts are enabled, until source i is acknowledged.
- R3: An interrupt is taken only at an edge where `ie_o` = 1, `boundary_i` = 1, at least one flag is pending and the unit is idle. Taking it clears `ie_o`, and `busy_o` rises in the next cycle.
- R4: Among the pending sources, the lowest index (the lowest vector) wins. Only the winner's pending flag is cleared.
- R5: In the first busy cycle the unit writes one byte at address `sp_i` (as sampled when the interrupt was taken). The byte holds carry in bit 7, zero in bit 6 and PC[13:8] in bits 5..0.
- R6: In the second busy cycle the unit writes PC[7:0] at the captured pointer plus 1.
- R7: Each of the two writes comes with `sp_we_o` = 1. `sp_next_o` is the captured pointer plus 1 in the first write and plus 2 in the second.
- R8: In the third busy cycle `pc_load_o` = 1 and `pc_next_o` = 2*(i+1) for winning source i. The unit is then idle again.
- R9: `ie_set_i` sets `ie_o` at the next edge. At the edge where an interrupt is taken, clearing wins over a simultaneous `ie_set_i`.
- R10: Requests that arrive during the sequence become pending and do not change the vector or the bytes of the sequence in progress.
- R11: The saved bytes come from `pc_i`, `carry_i` and `zero_i` as sampled when the interrupt was taken. Changes to these inputs during the sequence have no effect on the saved bytes.
- R12: A request from the winning source, arriving at the same edge as the interrupt is taken, leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | NUM_SRC | Request per source; bit 0 has the highest priority |
| ie_set_i | input | 1 | Sets the global interrupt enable |
| boundary_i | input | 1 | The core is at an instruction boundary and can take an interrupt |
| pc_i | input | PC_W | Return program counter |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| sp_i | input | SP_W | Current stack pointer |
| ie_o | output | 1 | Global interrupt enable |
| pend_o | output | NUM_SRC | Pending flags |
| busy_o | output | 1 | Acknowledge sequence in progress |
| mem_we_o | output | 1 | Data-memory write strobe |
| mem_addr_o | output | SP_W | Data-memory write address |
| mem_wdata_o | output | BYTE_W | Data-memory write byte |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_next_o | output | SP_W | New stack pointer value |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_next_o | output | PC_W | Program counter value to load |

## Verification
The acknowledge path is driven with single, paired and full sets of requests. Some are left pending from earlier cases, so the table shows whether the lowest index wins and whether only that flag is cleared. The table also varies the stack pointer, including a value at the top of its range, together with PC and flag values that have distinct upper and lower halves. This separates the two bytes and their order, and checks that the pointer wraps. Directed cases hold requests while interrupts are disabled or no boundary is signalled. Other directed cases race `ie_set_i` and a repeat request against the acknowledge edge, and inject a higher-priority request and changed PC inputs during a sequence, to show that the context was latched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_BOOT    = 3'd0,
    ST_IDLE    = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_PUSH_LO = 3'd3,
    ST_VECTOR  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    logic flag_q;
    // a new request beats the acknowledge clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC    = 3,
  parameter int PC_W       = 14,
  parameter int VEC_STRIDE = 2
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [PC_W-1:0]    vec_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = PC_W'((i + 1) * VEC_STRIDE);
      end
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_ctx_pack.sv
module irq_ctx_pack #(
  parameter int PC_W   = 14,
  parameter int BYTE_W = 8
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  // PC_W must equal 2*BYTE_W-2 so both flags fit in the upper byte
  localparam int HI_PC_W = PC_W - BYTE_W;
  logic [HI_PC_W-1:0] pc_hi;
  assign pc_hi = pc_i[PC_W-1:BYTE_W];
  assign hi_o  = {carry_i, zero_i, pc_hi};
  assign lo_o  = pc_i[BYTE_W-1:0];
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PC_W    = 14,
  parameter int SP_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               any_i,
  input  logic [NUM_SRC-1:0] grant_i,
  input  logic [PC_W-1:0]    vec_i,
  input  logic               ie_set_i,
  input  logic               boundary_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               carry_i,
  input  logic               zero_i,
  input  logic [SP_W-1:0]    sp_i,
  output seq_state_e         state_o,
  output logic               ie_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [PC_W-1:0]    pc_q_o,
  output logic               carry_q_o,
  output logic               zero_q_o,
  output logic [SP_W-1:0]    sp_q_o,
  output logic [PC_W-1:0]    vec_q_o
);
  seq_state_e state_q, state_d;
  logic       ie_q;
  logic       take;

  assign take = (state_q == ST_IDLE) && ie_q && any_i && boundary_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOT:    state_d = ST_IDLE;
      ST_IDLE:    if (take) state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_VECTOR;
      ST_VECTOR:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT;
      ie_q      <= 1'b0;
      pc_q_o    <= '0;
      carry_q_o <= 1'b0;
      zero_q_o  <= 1'b0;
      sp_q_o    <= '0;
      vec_q_o   <= '0;
    end else begin
      state_q <= state_d;
      if (take)          ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
      if (take) begin
        pc_q_o    <= pc_i;
        carry_q_o <= carry_i;
        zero_q_o  <= zero_i;
        sp_q_o    <= sp_i;
        vec_q_o   <= vec_i;
      end
    end
  end

  assign state_o = state_q;
  assign ie_o    = ie_q;
  assign clr_o   = take ? grant_i : '0;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int NUM_SRC    = 3,
  parameter int PC_W       = 14,
  parameter int BYTE_W     = 8,
  parameter int SP_W       = 8,
  parameter int VEC_STRIDE = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               ie_set_i,
  input  logic               boundary_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               carry_i,
  input  logic               zero_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic               ie_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  output logic               sp_we_o,
  output logic [SP_W-1:0]    sp_next_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_next_o
);
  localparam logic [PC_W-1:0] RESET_PC = '0;

  logic [NUM_SRC-1:0] clr, grant;
  logic               any;
  logic [PC_W-1:0]    vec, vec_q, pc_q;
  logic               carry_q, zero_q;
  logic [SP_W-1:0]    sp_q;
  logic [BYTE_W-1:0]  byte_hi, byte_lo;
  seq_state_e         state;

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_req_i),
    .clr_i  (clr),
    .pend_o (pend_o)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .VEC_STRIDE(VEC_STRIDE)) u_arbiter (
    .pend_i  (pend_o),
    .any_o   (any),
    .grant_o (grant),
    .vec_o   (vec)
  );

  irq_seq #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .SP_W(SP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any),
    .grant_i    (grant),
    .vec_i      (vec),
    .ie_set_i   (ie_set_i),
    .boundary_i (boundary_i),
    .pc_i       (pc_i),
    .carry_i    (carry_i),
    .zero_i     (zero_i),
    .sp_i       (sp_i),
    .state_o    (state),
    .ie_o       (ie_o),
    .clr_o      (clr),
    .pc_q_o     (pc_q),
    .carry_q_o  (carry_q),
    .zero_q_o   (zero_q),
    .sp_q_o     (sp_q),
    .vec_q_o    (vec_q)
  );

  irq_ctx_pack #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_pack (
    .pc_i    (pc_q),
    .carry_i (carry_q),
    .zero_i  (zero_q),
    .hi_o    (byte_hi),
    .lo_o    (byte_lo)
  );

  always_comb begin
    busy_o      = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = byte_hi;
    sp_we_o     = 1'b0;
    sp_next_o   = sp_q + SP_W'(1);
    pc_load_o   = 1'b0;
    pc_next_o   = RESET_PC;
    case (state)
      ST_BOOT: pc_load_o = 1'b1;
      ST_PUSH_HI: begin
        busy_o   = 1'b1;
        mem_we_o = 1'b1;
        sp_we_o  = 1'b1;
      end
      ST_PUSH_LO: begin
        busy_o      = 1'b1;
        mem_we_o    = 1'b1;
        sp_we_o     = 1'b1;
        mem_addr_o  = sp_q + SP_W'(1);
        mem_wdata_o = byte_lo;
        sp_next_o   = sp_q + SP_W'(2);
      end
      ST_VECTOR: begin
        busy_o    = 1'b1;
        pc_load_o = 1'b1;
        pc_next_o = vec_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int NUM_SRC = 3,
  parameter int PC_W    = 14,
  parameter int SP_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ie_o,
  input logic [NUM_SRC-1:0] pend_o,
  input logic               busy_o,
  input logic               mem_we_o,
  input logic [SP_W-1:0]    mem_addr_o,
  input logic               sp_we_o,
  input logic [SP_W-1:0]    sp_next_o,
  input logic               pc_load_o,
  input logic [PC_W-1:0]    pc_next_o
);
  assert_boot_vector_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && !busy_o) |-> (pc_next_o == '0));

  assert_hold_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ie_o) |-> ((pend_o & $past(pend_o)) == $past(pend_o)));

  assert_ack_disables_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !ie_o);

  assert_push_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == SP_W'($past(mem_addr_o) + 1'b1)));

  assert_sp_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (mem_we_o && sp_next_o == SP_W'(mem_addr_o + 1'b1)));

  assert_vector_after_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && busy_o) |-> $past(mem_we_o));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .NUM_SRC(NUM_SRC), .PC_W(PC_W), .SP_W(SP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ie_o       (ie_o),
  .pend_o     (pend_o),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .sp_we_o    (sp_we_o),
  .sp_next_o  (sp_next_o),
  .pc_load_o  (pc_load_o),
  .pc_next_o  (pc_next_o)
);

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic        ie_set = 1'b0, boundary = 1'b0;
  logic [13:0] pc = '0;
  logic        carry = 1'b0, zero = 1'b0;
  logic [7:0]  sp = '0;
  logic        ie, busy, mem_we, sp_we, pc_load;
  logic [2:0]  pend;
  logic [7:0]  mem_addr, mem_wdata, sp_next;
  logic [13:0] pc_next;

  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_pend = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .ie_set_i(ie_set),
    .boundary_i(boundary), .pc_i(pc), .carry_i(carry), .zero_i(zero), .sp_i(sp),
    .ie_o(ie), .pend_o(pend), .busy_o(busy), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .sp_we_o(sp_we),
    .sp_next_o(sp_next), .pc_load_o(pc_load), .pc_next_o(pc_next)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  req;
    logic [13:0] pc;
    logic        c;
    logic        z;
    logic [7:0]  sp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'b001, 14'h1234, 1'b1, 1'b0, 8'h10},
    '{3'b110, 14'h3fff, 1'b0, 1'b1, 8'h40},
    '{3'b000, 14'h0a5c, 1'b1, 1'b1, 8'hff},
    '{3'b111, 14'h2001, 1'b0, 1'b0, 8'h00},
    '{3'b000, 14'h0100, 1'b1, 1'b0, 8'h7e},
    '{3'b100, 14'h15aa, 1'b0, 1'b1, 8'h20}
  };

  task automatic post_req(logic [2:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
    req = '0;
    exp_pend |= r;
    check("R2 pend latched", 32'(pend), 32'(exp_pend));
    check("R2 ie stays off", 32'(ie), 0);
  endtask

  task automatic enable();
    @(negedge clk);
    ie_set = 1'b1;
    @(negedge clk);
    ie_set = 1'b0;
    check("R9 ie set", 32'(ie), 1);
  endtask

  // runs one acknowledge with the pending set already in exp_pend
  task automatic do_ack(logic [13:0] p, logic c, logic z, logic [7:0] s,
                        logic [2:0] race_req, logic race_ie, logic [2:0] mid_req);
    int win = 0;
    logic [13:0] exp_vec;
    logic [7:0]  hi, lo;
    for (int i = 2; i >= 0; i--) if (exp_pend[i]) win = i;
    exp_vec = 14'((win + 1) * 2);
    hi = {c, z, p[13:8]};
    lo = p[7:0];
    @(negedge clk);
    check("R3 idle before", 32'(busy), 0);
    pc = p; carry = c; zero = z; sp = s;
    boundary = 1'b1; req = race_req; ie_set = race_ie;
    exp_pend[win] = 1'b0;
    exp_pend |= race_req;
    @(negedge clk);
    boundary = 1'b0; req = mid_req; ie_set = 1'b0;
    pc = ~p; carry = ~c; zero = ~z; sp = ~s;
    check("R3 busy", 32'(busy), 1);
    check("R3/R9 ie cleared", 32'(ie), 0);
    check("R4 pend after ack", 32'(pend), 32'(exp_pend));
    check("R5 we", 32'(mem_we), 1);
    check("R5 addr", 32'(mem_addr), 32'(s));
    check("R5/R11 hi byte", 32'(mem_wdata), 32'(hi));
    check("R7 sp_we hi", 32'(sp_we), 1);
    check("R7 sp+1", 32'(sp_next), 32'(8'(s + 8'd1)));
    check("R8 no load yet", 32'(pc_load), 0);
    exp_pend |= mid_req;
    @(negedge clk);
    req = '0;
    check("R6 we", 32'(mem_we), 1);
    check("R6 addr", 32'(mem_addr), 32'(8'(s + 8'd1)));
    check("R6/R11 lo byte", 32'(mem_wdata), 32'(lo));
    check("R7 sp+2", 32'(sp_next), 32'(8'(s + 8'd2)));
    check("R10 pend mid", 32'(pend), 32'(exp_pend));
    @(negedge clk);
    check("R8 load", 32'(pc_load), 1);
    check("R8/R10 vector", 32'(pc_next), 32'(exp_vec));
    check("R8 no write", 32'(mem_we), 0);
    @(negedge clk);
    check("R8 idle", 32'(busy), 0);
    check("R8 load off", 32'(pc_load), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state and boot load
    #12;
    check("R1 ie", 32'(ie), 0);
    check("R1 pend", 32'(pend), 0);
    check("R1 busy", 32'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 boot load", 32'(pc_load), 1);
    check("R1 boot pc", 32'(pc_next), 0);
    @(negedge clk);
    check("R1 load after boot", 32'(pc_load), 0);
    check("R1 idle", 32'(busy), 0);

    // vector table
    foreach (VECS[k]) begin
      if (VECS[k].req != '0) post_req(VECS[k].req);
      enable();
      do_ack(VECS[k].pc, VECS[k].c, VECS[k].z, VECS[k].sp, 3'b000, 1'b0, 3'b000);
    end
    // drain leftovers
    while (exp_pend != '0) begin
      enable();
      do_ack(14'h0042, 1'b0, 1'b0, 8'h30, 3'b000, 1'b0, 3'b000);
    end

    // R2/R3 pending while disabled with boundary; no take
    post_req(3'b010);
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    check("R3 no take while disabled", 32'(busy), 0);
    check("R2 still pending", 32'(pend), 32'(exp_pend));
    // R3 enabled but no boundary
    enable();
    @(negedge clk);
    @(negedge clk);
    check("R3 no take without boundary", 32'(busy), 0);
    check("R3 ie held", 32'(ie), 1);

    // R9/R12 race at the acknowledge edge; R10 higher source mid-sequence
    do_ack(14'h2b3c, 1'b1, 1'b1, 8'h55, 3'b010, 1'b1, 3'b001);
    check("R12 winner stays pending", 32'(pend[1]), 1);
    check("R9 ie remains cleared", 32'(ie), 0);
    enable();
    do_ack(14'h0003, 1'b0, 1'b1, 8'h60, 3'b000, 1'b0, 3'b000);
    enable();
    do_ack(14'h0004, 1'b1, 1'b0, 8'h62, 3'b000, 1'b0, 3'b000);
    check("R4 all drained", 32'(pend), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule